// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address. It adds the offset to the value of one of four 16-bit segment registers, shifted up by four bits. Each segment register therefore opens a 64 KB window that may start on any 16-byte boundary of a 1 MB space. The sum is cut to 20 bits, so a window that runs past the top of memory wraps round to address zero.

Which segment is used depends on what the access is for. Instruction fetches always use the code segment. Accesses through the stack or frame pointer use the stack segment, and other data accesses use the data segment. In string moves, the source uses the data segment and the destination always uses the extra segment. A caller may ask for a different segment. That request is honoured for data and string-source accesses, and it has no effect on fetches or string destinations.

A write port loads any segment register on the rising clock edge. Address generation is purely combinational from the register values held at that moment. The block reports both the address and the identity of the segment it used.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, the code segment register holds 16'hFFFF and the extra, stack and data segment registers hold 0.
- R2: `phys_addr_o` equals (segment value × 16 + `offset_i`) mod 2^20, so an address that passes 20'hFFFFF wraps to the bottom of memory.
- R3: When `acc_kind_i` = 0 (instruction fetch), the code segment is used, whatever `ptr_sel_i`, `ovr_valid_i` and `ovr_seg_i` are.
- R4: When `acc_kind_i` = 1 (data access) with no override, `ptr_sel_i` = 4 (stack pointer) or 5 (frame pointer) selects the stack segment.
- R5: When `acc_kind_i` = 1 with no override, any other `ptr_sel_i` code (0 none, 1 general register, 2 source index, 3 destination index, 6, 7) selects the data segment.
- R6: When `acc_kind_i` = 3 (string destination), the extra segment is used, whatever the override inputs are.
- R7: When `acc_kind_i` = 2 (string source) with no override, the data segment is used, whatever `ptr_sel_i` is.
- R8: When `ovr_valid_i` = 1 and `acc_kind_i` is 1 or 2, the segment named by `ovr_seg_i` is used in place of the default.
- R9: A write with `sw_en_i` = 1 loads `sw_data_i` into the register named by `sw_sel_i` at the rising clock edge. The address in the same cycle still uses the old value, and from the next cycle on it uses the new one.
- R10: `seg_used_o` names the segment that formed the address. Segment codes, used by `seg_used_o`, `ovr_seg_i` and `sw_sel_i`, are 0 extra, 1 code, 2 stack, 3 data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind_i | input | 2 | Access kind: 0 fetch, 1 data, 2 string source, 3 string destination |
| ptr_sel_i | input | 3 | Addressing register: 0 none, 1 general, 2 source index, 3 destination index, 4 stack pointer, 5 frame pointer |
| offset_i | input | 16 | Offset within the segment |
| ovr_valid_i | input | 1 | Segment override request |
| ovr_seg_i | input | 2 | Requested segment code |
| sw_en_i | input | 1 | Segment register write enable |
| sw_sel_i | input | 2 | Segment register to write |
| sw_data_i | input | 16 | Value to write |
| phys_addr_o | output | 20 | Physical address |
| seg_used_o | output | 2 | Code of the segment used |

## Verification
The assertions check the segment-selection rules on every cycle. These cover fixed segments for fetches and string destinations, stack and data defaults, and honoured overrides. They also check that a just-written register value appears in the next cycle's address, including the 20-bit wrap. The reset values can only be seen in the bench's scenarios. So can the old value that shows in the write cycle itself, and the full cross of access kinds, pointer codes, override settings and boundary offsets against independently loaded register contents.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH   = 2'd0,
        ACC_DATA    = 2'd1,
        ACC_STR_SRC = 2'd2,
        ACC_STR_DST = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        PTR_NONE    = 3'd0,
        PTR_GEN     = 3'd1,
        PTR_SRC_IDX = 3'd2,
        PTR_DST_IDX = 3'd3,
        PTR_STACK   = 3'd4,
        PTR_FRAME   = 3'd5
    } ptr_kind_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int               SEG_W     = 16,
    parameter int               NUM_SEG   = 4,
    parameter int               SEL_W     = 2,
    parameter int               CODE_IDX  = 1,
    parameter logic [SEG_W-1:0] CODE_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [NUM_SEG-1:0][SEG_W-1:0] regs;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam logic [SEG_W-1:0] INIT = (g == CODE_IDX) ? CODE_INIT : '0;
        logic [SEG_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= INIT;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                q <= wr_data;
            end
        end

        assign regs[g] = q;
    end

    assign rd_data = regs[rd_sel];

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_pkg::*;
(
    input  acc_kind_e acc_i,
    input  ptr_kind_e ptr_i,
    input  logic      ovr_valid_i,
    input  seg_id_e   ovr_seg_i,
    output seg_id_e   seg_o
);

    seg_id_e dflt;
    logic    locked;

    always_comb begin
        dflt   = SEG_DATA;
        locked = 1'b0;
        unique case (acc_i)
            ACC_FETCH: begin
                dflt   = SEG_CODE;
                locked = 1'b1;
            end
            ACC_STR_DST: begin
                dflt   = SEG_EXTRA;
                locked = 1'b1;
            end
            ACC_STR_SRC: begin
                dflt   = SEG_DATA;
                locked = 1'b0;
            end
            ACC_DATA: begin
                dflt   = ((ptr_i == PTR_STACK) || (ptr_i == PTR_FRAME)) ? SEG_STACK : SEG_DATA;
                locked = 1'b0;
            end
            default: begin
                dflt   = SEG_DATA;
                locked = 1'b0;
            end
        endcase
    end

    always_comb begin
        seg_o = (ovr_valid_i && !locked) ? ovr_seg_i : dflt;
    end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20
) (
    input  logic [SEG_W-1:0] seg_val_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [PA_W-1:0]  pa_o
);

    localparam int BASE_W = SEG_W + SEG_SHIFT;

    logic [BASE_W-1:0] base;

    assign base = {seg_val_i, {SEG_SHIFT{1'b0}}};
    assign pa_o = PA_W'(base) + PA_W'(offset_i);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       acc_kind_i,
    input  logic [2:0]       ptr_sel_i,
    input  logic [OFS_W-1:0] offset_i,
    input  logic             ovr_valid_i,
    input  logic [1:0]       ovr_seg_i,
    input  logic             sw_en_i,
    input  logic [1:0]       sw_sel_i,
    input  logic [SEG_W-1:0] sw_data_i,
    output logic [PA_W-1:0]  phys_addr_o,
    output logic [1:0]       seg_used_o
);

    localparam logic [SEG_W-1:0] CODE_INIT = '1;

    seg_id_e          seg_sel;
    logic [SEG_W-1:0] seg_val;

    seg_select u_select (
        .acc_i       (acc_kind_e'(acc_kind_i)),
        .ptr_i       (ptr_kind_e'(ptr_sel_i)),
        .ovr_valid_i (ovr_valid_i),
        .ovr_seg_i   (seg_id_e'(ovr_seg_i)),
        .seg_o       (seg_sel)
    );

    seg_regfile #(
        .SEG_W     (SEG_W),
        .NUM_SEG   (NUM_SEG),
        .SEL_W     (SEL_W),
        .CODE_IDX  (int'(SEG_CODE)),
        .CODE_INIT (CODE_INIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sw_en_i),
        .wr_sel  (sw_sel_i),
        .wr_data (sw_data_i),
        .rd_sel  (seg_sel),
        .rd_data (seg_val)
    );

    seg_adder #(
        .SEG_W     (SEG_W),
        .OFS_W     (OFS_W),
        .SEG_SHIFT (SEG_SHIFT),
        .PA_W      (PA_W)
    ) u_add (
        .seg_val_i (seg_val),
        .offset_i  (offset_i),
        .pa_o      (phys_addr_o)
    );

    assign seg_used_o = seg_sel;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       acc_kind_i,
    input logic [2:0]       ptr_sel_i,
    input logic [OFS_W-1:0] offset_i,
    input logic             ovr_valid_i,
    input logic [1:0]       ovr_seg_i,
    input logic             sw_en_i,
    input logic [1:0]       sw_sel_i,
    input logic [SEG_W-1:0] sw_data_i,
    input logic [PA_W-1:0]  phys_addr_o,
    input logic [1:0]       seg_used_o
);

    logic via_stack;
    assign via_stack = (ptr_sel_i == 3'd4) || (ptr_sel_i == 3'd5);

    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (acc_kind_i == 2'd0) |-> (seg_used_o == 2'd1));

    AST_STRDST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (acc_kind_i == 2'd3) |-> (seg_used_o == 2'd0));

    AST_DATA_STACK: assert property (@(posedge clk) disable iff (!rst_n) // R4
        (!ovr_valid_i && acc_kind_i == 2'd1 && via_stack) |-> (seg_used_o == 2'd2));

    AST_DATA_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n) // R5
        (!ovr_valid_i && acc_kind_i == 2'd1 && !via_stack) |-> (seg_used_o == 2'd3));

    AST_STRSRC_DATA: assert property (@(posedge clk) disable iff (!rst_n) // R7
        (!ovr_valid_i && acc_kind_i == 2'd2) |-> (seg_used_o == 2'd3));

    AST_OVERRIDE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) // R8
        (ovr_valid_i && (acc_kind_i == 2'd1 || acc_kind_i == 2'd2)) |-> (seg_used_o == ovr_seg_i));

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n) // R9
        ($past(rst_n) && $past(sw_en_i) && !sw_en_i && (seg_used_o == $past(sw_sel_i)))
        |-> (phys_addr_o == (PA_W'({$past(sw_data_i), {SEG_SHIFT{1'b0}}}) + PA_W'(offset_i))));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
    .SEG_W     (SEG_W),
    .OFS_W     (OFS_W),
    .SEG_SHIFT (SEG_SHIFT),
    .PA_W      (PA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_kind_i  (acc_kind_i),
    .ptr_sel_i   (ptr_sel_i),
    .offset_i    (offset_i),
    .ovr_valid_i (ovr_valid_i),
    .ovr_seg_i   (ovr_seg_i),
    .sw_en_i     (sw_en_i),
    .sw_sel_i    (sw_sel_i),
    .sw_data_i   (sw_data_i),
    .phys_addr_o (phys_addr_o),
    .seg_used_o  (seg_used_o)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_kind_i = '0;
    logic [2:0]  ptr_sel_i = '0;
    logic [15:0] offset_i = '0;
    logic        ovr_valid_i = 1'b0;
    logic [1:0]  ovr_seg_i = '0;
    logic        sw_en_i = 1'b0;
    logic [1:0]  sw_sel_i = '0;
    logic [15:0] sw_data_i = '0;
    logic [19:0] phys_addr_o;
    logic [1:0]  seg_used_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int model [4];

    always #4 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_kind_i  (acc_kind_i),
        .ptr_sel_i   (ptr_sel_i),
        .offset_i    (offset_i),
        .ovr_valid_i (ovr_valid_i),
        .ovr_seg_i   (ovr_seg_i),
        .sw_en_i     (sw_en_i),
        .sw_sel_i    (sw_sel_i),
        .sw_data_i   (sw_data_i),
        .phys_addr_o (phys_addr_o),
        .seg_used_o  (seg_used_o)
    );

    function automatic int exp_seg(int acc, int ptr, bit ov, int ovs);
        if (acc == 0) return 1;
        if (acc == 3) return 0;
        if (ov) return ovs;
        if (acc == 2) return 3;
        if (ptr == 4 || ptr == 5) return 2;
        return 3;
    endfunction

    function automatic string seg_tag(int acc, int ptr, bit ov);
        if (acc == 0) return "R3";
        if (acc == 3) return "R6";
        if (ov) return "R8";
        if (acc == 2) return "R7";
        if (ptr == 4 || ptr == 5) return "R4";
        return "R5";
    endfunction

    function automatic int exp_pa(int segv, int off);
        return (segv * 16 + off) % 1048576;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(int acc, int ptr, bit ov, int ovs, int off);
        acc_kind_i  = 2'(acc);
        ptr_sel_i   = 3'(ptr);
        ovr_valid_i = ov;
        ovr_seg_i   = 2'(ovs);
        offset_i    = 16'(off);
    endtask

    task automatic probe(int acc, int ptr, bit ov, int ovs, int off);
        int s;
        @(negedge clk);
        drive(acc, ptr, ov, ovs, off);
        #1;
        s = exp_seg(acc, ptr, ov, ovs);
        check({seg_tag(acc, ptr, ov), "/R10 seg"}, int'(seg_used_o), s);
        check("R2 addr", int'(phys_addr_o), exp_pa(model[s], off));
    endtask

    task automatic write_seg(int sel, int val);
        @(negedge clk);
        drive(1, 1, 1'b1, sel, 0);
        sw_en_i   = 1'b1;
        sw_sel_i  = 2'(sel);
        sw_data_i = 16'(val);
        #1;
        check("R9 old value in write cycle", int'(phys_addr_o), exp_pa(model[sel], 0));
        @(negedge clk);
        sw_en_i = 1'b0;
        #1;
        model[sel] = val;
        check("R9 new value after edge", int'(phys_addr_o), exp_pa(val, 0));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model[0] = 0;
        model[1] = 16'hFFFF;
        model[2] = 0;
        model[3] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents, observed through each segment
        @(negedge clk);
        drive(0, 0, 1'b0, 0, 0);
        #1;
        check("R1 code reset", int'(phys_addr_o), 20'hFFFF0);
        check("R10 code code", int'(seg_used_o), 1);
        for (int s = 0; s < 4; s++) begin
            if (s != 1) begin
                @(negedge clk);
                drive(1, 0, 1'b1, s, 16'h0005);
                #1;
                check("R1 other reset", int'(phys_addr_o), 5);
                check("R10 override code", int'(seg_used_o), s);
            end
        end

        // R2 wrap with the reset code segment
        probe(0, 0, 1'b0, 0, 16'h0010);
        probe(0, 0, 1'b0, 0, 16'hFFFF);

        // R9 loads
        write_seg(0, 16'h1234);
        write_seg(1, 16'hF000);
        write_seg(2, 16'h8001);
        write_seg(3, 16'hFFFF);

        // R2 explicit wrap past the top of memory
        @(negedge clk);
        drive(2, 0, 1'b0, 0, 16'hFFFF);
        #1;
        check("R2 wrap", int'(phys_addr_o), 20'h0FFEF);

        // Full sweep of selection rules
        for (int acc = 0; acc < 4; acc++)
            for (int ptr = 0; ptr < 8; ptr++)
                for (int ov = 0; ov < 2; ov++)
                    for (int ovs = 0; ovs < 4; ovs++)
                        for (int k = 0; k < 4; k++) begin
                            int off;
                            case (k)
                                0: off = 16'h0000;
                                1: off = 16'h0010;
                                2: off = 16'hFFFF;
                                default: off = 16'h8421;
                            endcase
                            probe(acc, ptr, ov[0], ovs, off);
                        end

        // Reload and resweep the data path with new contents
        write_seg(2, 16'h0000);
        write_seg(3, 16'hABCD);
        for (int ptr = 0; ptr < 8; ptr++) probe(1, ptr, 1'b0, 0, 16'h7777);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule